// File: doc/BRIEF.md
# Secure Debug Authentication Controller

This block decides, cycle by cycle, whether the processor may be debugged and in which way. It takes three external enable pins (a global debug enable, a secure-privileged invasive enable and a secure-privileged non-invasive enable), two secure-user control bits, the current security bit and the processor mode code. From these it produces an invasive-permitted flag, a non-invasive-permitted flag, the selected debug mode and a filtered set of debug events. Halting debug that is granted only through the secure-user bit also raises a restricted-capabilities flag.

The three external pins are brought into the clock domain through two-flop synchronisers. Software sees the synchronised secure enables as status bits. No status bit exists for the global enable. Software can still probe it through the two-bit mode-select field, which always reads zero while the synchronised global enable is low.

The mode field is held by a four-state machine. The states are OFF, NONE, MON and HALT.
- OFF → NONE when the synchronised global enable is high.
- NONE, MON and HALT → OFF when that enable is low.
- Otherwise a write moves the machine to NONE (data 00), MON (data 10) or HALT (data 01 or 11).
- Without a write the state holds.

Top module: `dbg_auth_ctrl`

## Requirements
- R1: In reset and directly after it, the field reads 00, both status bits are 0, the mode flags, permissions and restricted flag are 0, and no event passes.
- R2: Each external pin passes two flip-flops that reset to 0. A pin change shows on the status bits and in the permissions exactly two rising edges later.
- R3: While the synchronised global enable is low, the field reads 00, both mode flags are low, both permissions are low, no event passes and restricted is low. Once the enable returns, the field reads 00 until it is written.
- R4: A write (fld_we=1) on a rising edge where the synchronised global enable is high sets the field as follows: data 00 gives none (reads 00, both flags low), 10 gives monitor (reads 10, mode_mon=1) and 01 or 11 gives halting (reads 01, mode_halt=1).
- R5: The context is secure when ns_bit=0 or cpu_mode equals MON_CODE. The user mode is cpu_mode equal to USER_CODE. Invasive debug is permitted when the global enable is high and one of these holds:
  - the context is non-secure;
  - the synchronised secure invasive enable is high;
  - the context is secure user mode and usr_inv_bit=1.
- R6: With cpu_mode equal to MON_CODE, the context is secure even when ns_bit=1. With the secure enable low, neither permission is granted there.
- R7: Non-invasive permission follows R5 with the secure non-invasive enable and usr_ninv_bit in place of the invasive ones.
- R8: Event bit positions are 0 for a breakpoint instruction, 1 for an external request, 2 for a halt request and 3 for any other debug event. With invasive debug not permitted, no event passes, but the mode flags still report the field. With the field reading 00, only bits 0 to 2 may pass. In monitor or halting mode, every event passes.
- R9: restricted is high exactly when halting mode is selected, invasive debug is permitted, the context is secure and the synchronised secure invasive enable is low.
- R10: A write on an edge where the synchronised global enable is low is discarded. This holds even when the enable was high one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_dbg_en | input | 1 | Global debug enable pin (asynchronous) |
| pin_sec_inv_en | input | 1 | Secure privileged invasive enable pin (asynchronous) |
| pin_sec_ninv_en | input | 1 | Secure privileged non-invasive enable pin (asynchronous) |
| usr_inv_bit | input | 1 | Secure-user invasive control bit |
| usr_ninv_bit | input | 1 | Secure-user non-invasive control bit |
| ns_bit | input | 1 | 1 = non-secure state |
| cpu_mode | input | MODE_W | Processor mode code |
| fld_we | input | 1 | Mode field write enable |
| fld_wdata | input | 2 | Mode field write data |
| evt_in | input | 4 | Raw debug events |
| evt_out | output | 4 | Filtered debug events |
| field_rd | output | 2 | Mode field read-back |
| mode_mon | output | 1 | Monitor mode selected |
| mode_halt | output | 1 | Halting mode selected |
| inv_ok | output | 1 | Invasive debug permitted |
| ninv_ok | output | 1 | Non-invasive debug permitted |
| restricted | output | 1 | Halting granted through the user bit |
| stat_sec_inv | output | 1 | Synchronised secure invasive enable |
| stat_sec_ninv | output | 1 | Synchronised secure non-invasive enable |

## Verification
A field write can land on the same edge where the synchronised global enable falls. The enable must win and the write must be lost. The bench provokes this directly: it drops the pin, waits until the second synchroniser stage is low, and then presents a write on the next edge. It judges the result by the read-back staying 00 after the enable returns. In the random phase, the pin drops, the writes and the mode changes are mixed freely, so a write also meets the enable's rising edge and the one cycle where both are in transit. Each of these cases is compared with a cycle-accurate model kept in the bench.

// File: rtl/dbg_auth_pkg.sv
package dbg_auth_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_NONE = 2'd1,
        ST_MON  = 2'd2,
        ST_HALT = 2'd3
    } dbg_st_e;

    localparam int EVT_W     = 4;
    localparam int EVT_OTHER = 3;
    localparam int PIN_N     = 3;
    localparam int PIN_DBG   = 0;
    localparam int PIN_SINV  = 1;
    localparam int PIN_SNINV = 2;
endpackage

// File: rtl/dbg_sync.sv
module dbg_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_pin
            logic [STAGES-1:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d_async[g]};
            end
            assign q_sync[g] = chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/dbg_mode_fsm.sv
module dbg_mode_fsm
    import dbg_auth_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en_s,
    input  logic       we,
    input  logic [1:0] wdata,
    output dbg_st_e    st,
    output logic [1:0] field_rd,
    output logic       mode_mon,
    output logic       mode_halt
);
    dbg_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_OFF;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OFF: if (en_s) st_d = ST_NONE;
            ST_NONE, ST_MON, ST_HALT: begin
                if (!en_s)          st_d = ST_OFF;
                else if (we) begin
                    if (wdata[0])   st_d = ST_HALT;
                    else if (wdata[1]) st_d = ST_MON;
                    else            st_d = ST_NONE;
                end
            end
        endcase
    end

    always_comb begin
        field_rd  = 2'b00;
        mode_mon  = 1'b0;
        mode_halt = 1'b0;
        unique case (st_q)
            ST_OFF, ST_NONE: ;
            ST_MON:  begin field_rd = 2'b10; mode_mon  = en_s; end
            ST_HALT: begin field_rd = 2'b01; mode_halt = en_s; end
        endcase
        if (!en_s) field_rd = 2'b00;
    end

    assign st = st_q;
endmodule

// File: rtl/dbg_perm.sv
module dbg_perm (
    input  logic en_s,
    input  logic sec_ctx,
    input  logic is_user,
    input  logic sec_en_s,
    input  logic usr_bit,
    output logic ok
);
    always_comb begin
        ok = 1'b0;
        if (en_s) begin
            if (!sec_ctx || sec_en_s) ok = 1'b1;
            else                      ok = is_user & usr_bit;
        end
    end
endmodule

// File: rtl/dbg_evt_filter.sv
module dbg_evt_filter
    import dbg_auth_pkg::*;
(
    input  dbg_st_e          st,
    input  logic             inv_ok,
    input  logic [EVT_W-1:0] evt_in,
    output logic [EVT_W-1:0] evt_out
);
    logic [EVT_W-1:0] mask;

    always_comb begin
        mask = '1;
        unique case (st)
            ST_OFF, ST_NONE: mask[EVT_OTHER] = 1'b0;
            ST_MON, ST_HALT: ;
        endcase
        evt_out = inv_ok ? (evt_in & mask) : '0;
    end
endmodule

// File: rtl/dbg_auth_ctrl.sv
module dbg_auth_ctrl
    import dbg_auth_pkg::*;
#(
    parameter int               MODE_W    = 3,
    parameter logic [MODE_W-1:0] USER_CODE = 3'd0,
    parameter logic [MODE_W-1:0] MON_CODE  = 3'd7,
    parameter int               SYNC_STG  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pin_dbg_en,
    input  logic              pin_sec_inv_en,
    input  logic              pin_sec_ninv_en,
    input  logic              usr_inv_bit,
    input  logic              usr_ninv_bit,
    input  logic              ns_bit,
    input  logic [MODE_W-1:0] cpu_mode,
    input  logic              fld_we,
    input  logic [1:0]        fld_wdata,
    input  logic [3:0]        evt_in,
    output logic [3:0]        evt_out,
    output logic [1:0]        field_rd,
    output logic              mode_mon,
    output logic              mode_halt,
    output logic              inv_ok,
    output logic              ninv_ok,
    output logic              restricted,
    output logic              stat_sec_inv,
    output logic              stat_sec_ninv
);
    logic [PIN_N-1:0] pins_a, pins_s;
    logic             en_s, sinv_s, sninv_s, sec_ctx, is_user;
    dbg_st_e          st;

    assign pins_a[PIN_DBG]   = pin_dbg_en;
    assign pins_a[PIN_SINV]  = pin_sec_inv_en;
    assign pins_a[PIN_SNINV] = pin_sec_ninv_en;

    dbg_sync #(.N(PIN_N), .STAGES(SYNC_STG)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pins_a), .q_sync(pins_s)
    );

    assign en_s    = pins_s[PIN_DBG];
    assign sinv_s  = pins_s[PIN_SINV];
    assign sninv_s = pins_s[PIN_SNINV];

    assign sec_ctx = !ns_bit || (cpu_mode == MON_CODE);
    assign is_user = (cpu_mode == USER_CODE);

    dbg_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .en_s(en_s), .we(fld_we), .wdata(fld_wdata),
        .st(st), .field_rd(field_rd), .mode_mon(mode_mon), .mode_halt(mode_halt)
    );

    dbg_perm u_perm_inv (
        .en_s(en_s), .sec_ctx(sec_ctx), .is_user(is_user),
        .sec_en_s(sinv_s), .usr_bit(usr_inv_bit), .ok(inv_ok)
    );

    dbg_perm u_perm_ninv (
        .en_s(en_s), .sec_ctx(sec_ctx), .is_user(is_user),
        .sec_en_s(sninv_s), .usr_bit(usr_ninv_bit), .ok(ninv_ok)
    );

    dbg_evt_filter u_filt (
        .st(st), .inv_ok(inv_ok), .evt_in(evt_in), .evt_out(evt_out)
    );

    assign restricted    = mode_halt && inv_ok && sec_ctx && !sinv_s;
    assign stat_sec_inv  = sinv_s;
    assign stat_sec_ninv = sninv_s;
endmodule

// File: rtl/dbg_auth_chk.sv
module dbg_auth_chk #(
    parameter int               MODE_W   = 3,
    parameter logic [MODE_W-1:0] MON_CODE = 3'd7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              en_s,
    input logic              pin_sec_inv_en,
    input logic [MODE_W-1:0] cpu_mode,
    input logic [3:0]        evt_in,
    input logic [3:0]        evt_out,
    input logic [1:0]        field_rd,
    input logic              mode_mon,
    input logic              mode_halt,
    input logic              inv_ok,
    input logic              ninv_ok,
    input logic              restricted,
    input logic              stat_sec_inv
);
    logic [1:0] cyc;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cyc <= 2'd0;
        else if (cyc != 2'd3) cyc <= cyc + 2'd1;
    end

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |-> (field_rd == 2'b00 && !inv_ok && !ninv_ok && evt_out == 4'b0 && !restricted)); // R3
    AST_WRITE_LOST: assert property (@(posedge clk) disable iff (!rst_n)
        !en_s |=> field_rd == 2'b00); // R10
    AST_SYNC_DELAY: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc >= 2'd2) |-> stat_sec_inv == $past(pin_sec_inv_en, 2)); // R2
    AST_MODE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mode_mon, mode_halt})); // R4
    AST_EVT_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_out & ~evt_in) == 4'b0); // R8
    AST_NONE_BLOCKS_OTHER: assert property (@(posedge clk) disable iff (!rst_n)
        field_rd == 2'b00 |-> !evt_out[3]); // R8
    AST_MON_SECURE: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_mode == MON_CODE && !stat_sec_inv) |-> !inv_ok); // R6
    AST_RESTRICT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
        restricted |-> (mode_halt && inv_ok && !stat_sec_inv)); // R9
endmodule

bind dbg_auth_ctrl dbg_auth_chk #(.MODE_W(MODE_W), .MON_CODE(MON_CODE)) u_chk (
    .clk(clk), .rst_n(rst_n), .en_s(en_s), .pin_sec_inv_en(pin_sec_inv_en),
    .cpu_mode(cpu_mode), .evt_in(evt_in), .evt_out(evt_out), .field_rd(field_rd),
    .mode_mon(mode_mon), .mode_halt(mode_halt), .inv_ok(inv_ok), .ninv_ok(ninv_ok),
    .restricted(restricted), .stat_sec_inv(stat_sec_inv)
);

// File: tb/tb_dbg_auth_ctrl.sv
module tb_dbg_auth_ctrl;
    localparam logic [2:0] USER_C = 3'd0;
    localparam logic [2:0] MON_C  = 3'd7;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       p_dbg = 1'b0, p_sinv = 1'b0, p_sninv = 1'b0;
    logic       u_inv = 1'b0, u_ninv = 1'b0, ns = 1'b0;
    logic [2:0] mode = 3'd1;
    logic       we = 1'b0;
    logic [1:0] wd = 2'b00;
    logic [3:0] ev = 4'b0;
    logic [3:0] evt_out;
    logic [1:0] field_rd;
    logic       mode_mon, mode_halt, inv_ok, ninv_ok, restricted, st_inv, st_ninv;

    dbg_auth_ctrl dut (
        .clk(clk), .rst_n(rst_n), .pin_dbg_en(p_dbg), .pin_sec_inv_en(p_sinv),
        .pin_sec_ninv_en(p_sninv), .usr_inv_bit(u_inv), .usr_ninv_bit(u_ninv),
        .ns_bit(ns), .cpu_mode(mode), .fld_we(we), .fld_wdata(wd), .evt_in(ev),
        .evt_out(evt_out), .field_rd(field_rd), .mode_mon(mode_mon),
        .mode_halt(mode_halt), .inv_ok(inv_ok), .ninv_ok(ninv_ok),
        .restricted(restricted), .stat_sec_inv(st_inv), .stat_sec_ninv(st_ninv)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    // bench model: synchroniser stages and field state (0 off, 1 none, 2 mon, 3 halt)
    logic [2:0] m1 = '0, m2 = '0;
    int         mst = 0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        if (!rst_n) begin
            m1 = '0; m2 = '0; mst = 0;
        end else begin
            if (!m2[0])          mst = 0;
            else if (mst == 0)   mst = 1;
            else if (we)         mst = wd[0] ? 3 : (wd[1] ? 2 : 1);
            m2 = m1;
            m1 = {p_sninv, p_sinv, p_dbg};
        end
    endtask

    function automatic logic perm(input logic sec_en, input logic ubit);
        logic sec = !ns || (mode == MON_C);
        return m2[0] && (!sec || sec_en || ((mode == USER_C) && ubit));
    endfunction

    task automatic compare_all();
        logic [1:0] e_fld;
        logic       e_inv, e_ninv, e_mon, e_halt, e_res;
        logic [3:0] e_ev;
        e_fld  = !m2[0] ? 2'b00 : (mst == 2 ? 2'b10 : (mst == 3 ? 2'b01 : 2'b00));
        e_mon  = m2[0] && mst == 2;
        e_halt = m2[0] && mst == 3;
        e_inv  = perm(m2[1], u_inv);
        e_ninv = perm(m2[2], u_ninv);
        e_ev   = !e_inv ? 4'b0 : ((e_mon || e_halt) ? ev : (ev & 4'b0111));
        e_res  = e_halt && e_inv && (!ns || mode == MON_C) && !m2[1];
        chk(field_rd == e_fld, "R3/R4 field_rd", field_rd, e_fld);
        chk({mode_mon, mode_halt} == {e_mon, e_halt}, "R4 mode flags", {mode_mon, mode_halt}, {e_mon, e_halt});
        chk(inv_ok == e_inv, "R5/R6 inv_ok", inv_ok, e_inv);
        chk(ninv_ok == e_ninv, "R7 ninv_ok", ninv_ok, e_ninv);
        chk(evt_out == e_ev, "R8 evt_out", evt_out, e_ev);
        chk(restricted == e_res, "R9 restricted", restricted, e_res);
        chk({st_ninv, st_inv} == m2[2:1], "R2 status", {st_ninv, st_inv}, m2[2:1]);
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        #(300000 * 10);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        p_dbg = 1; p_sinv = 1; p_sninv = 1; ev = 4'hf;
        repeat (3) tick();
        // R1: reset view
        chk(field_rd == 0 && !inv_ok && !ninv_ok && evt_out == 0 && !st_inv && !st_ninv && !restricted,
            "R1 reset state", {field_rd, inv_ok, evt_out}, 0);
        @(negedge clk); rst_n = 1;
        tick();
        chk(st_inv == 0, "R1 status after reset", st_inv, 0);
        tick();
        // R2: two-edge latency on the secure invasive pin
        chk(st_inv == 1, "R2 rise after two edges", st_inv, 1);
        p_sinv = 0; tick();
        chk(st_inv == 1, "R2 still old after one edge", st_inv, 1);
        tick();
        chk(st_inv == 0, "R2 new after two edges", st_inv, 0);
        // R4: 11 reads back as 01, halting; restricted via user bit (R9)
        we = 1; wd = 2'b11; tick(); we = 0;
        chk(field_rd == 2'b01 && mode_halt, "R4 write 11", field_rd, 1);
        ns = 0; mode = USER_C; u_inv = 1; tick();
        chk(restricted == 1 && inv_ok, "R9 secure user halting", restricted, 1);
        // R6: monitor code with ns=1 counts secure
        ns = 1; mode = MON_C; p_sninv = 0; tick(); tick(); tick();
        chk(!inv_ok && !ninv_ok, "R6 monitor secure", {inv_ok, ninv_ok}, 0);
        mode = 3'd2; tick();
        chk(inv_ok && ninv_ok, "R5/R7 non-secure privileged", {inv_ok, ninv_ok}, 3);
        // R8: not permitted still reports mode, blocks events
        ns = 0; u_inv = 0; we = 1; wd = 2'b10; tick(); we = 0;
        chk(mode_mon && evt_out == 0, "R8 suppressed but mode reported", {mode_mon, evt_out}, 16);
        // R10: write colliding with the falling synchronised enable
        p_dbg = 0; tick(); tick();
        we = 1; wd = 2'b01; tick(); we = 0;
        chk(field_rd == 0 && !mode_halt, "R10 write lost", field_rd, 0);
        p_dbg = 1; tick(); tick(); tick();
        chk(field_rd == 0, "R3 probe after re-enable", field_rd, 0);
        // random phase
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 16 == 0) p_sinv  = $urandom % 2;
            if ($urandom % 16 == 0) p_sninv = $urandom % 2;
            if ($urandom % 24 == 0) p_dbg   = ~p_dbg;
            else if (!p_dbg && $urandom % 4 == 0) p_dbg = 1;
            u_inv  = $urandom % 2;
            u_ninv = $urandom % 2;
            ns     = $urandom % 2;
            case ($urandom % 4)
                0: mode = USER_C;
                1: mode = MON_C;
                default: mode = 3'($urandom % 8);
            endcase
            we = ($urandom % 4 == 0);
            wd = 2'($urandom % 4);
            ev = 4'($urandom % 16);
            tick();
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule